// File: doc/BRIEF.md
# Nibble-coded register access decoder

This block sits at the device end of a byte-wide host link and turns a stream of command bytes into register accesses. Every byte holds an opcode in bits 7:4 and a four-bit payload in bits 3:0. The host builds an 8-bit register address from two address commands, and 8-bit write data from two data commands. The write is issued on the second data command, which carries the upper data nibble.

A read command returns one byte on a response stream: the content of the register currently addressed. A variant of the read command advances the address by one once the byte has been captured. A run of such reads therefore streams a multi-byte counter, least significant byte first. Two registers live inside the block. One is a fixed identification register and the other is a scratch register for link testing. All other addresses are served by an external register file: the block drives its write port and reads it through a combinational read-data input.

Top module: `nib_reg_decoder`

## Requirements
- R1: After reset the address is 0x00, the low data nibble latch is 0, the scratch register is 0x00, `rsp_valid_o` is 0 and `cmd_ready_o` is 1.
- R2: Opcode 0x0 loads address bits 3:0 from the payload, and opcode 0x1 loads address bits 7:4. The other address bits are kept. The address is visible on `rd_addr_o` and `wr_addr_o`.
- R3: Opcode 0x2 only latches the payload as the low data nibble and writes nothing. Opcode 0x3 raises `wr_en_o` in its acceptance cycle, with `wr_data_o` = {payload, latched low nibble} and `wr_addr_o` = the current address.
- R4: Several data-low/data-high pairs after one address each produce one write to that same address. Writes leave the address unchanged.
- R5: Opcode 0x4 returns exactly one byte, the addressed register. `rsp_valid_o` rises in the cycle after the command is accepted.
- R6: Opcode 0x5 returns the addressed register and then advances the address by one, wrapping from 0xFF to 0x00.
- R7: A read at address 0x00 (the identification register) returns 0xA6. Writes to that address do not change it.
- R8: A read at address 0x0F (the scratch register) returns the byte last written there.
- R9: A read at any other address returns `rd_data_i`, sampled with `rd_addr_o` equal to that address.
- R10: A response stays on `rsp_valid_o`/`rsp_data_o`, unchanged, until `rsp_ready_i` is high at a clock edge. While a response is pending, `cmd_ready_o` is 0 and no command is consumed.
- R11: Opcodes 0x6 to 0xF are consumed with no effect: no write, no response, and no change to the address.
- R12: An opcode 0x3 with no opcode 0x2 since reset writes {payload, 0x0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_data_i | input | 8 | Command byte: opcode 7:4, payload 3:0 |
| cmd_ready_o | output | 1 | Command byte accepted when high with valid |
| rsp_valid_o | output | 1 | Response byte valid |
| rsp_data_o | output | 8 | Response byte |
| rsp_ready_i | input | 1 | Response byte taken |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | 8 | External register read address |
| rd_data_i | input | 8 | External register read data, combinational from rd_addr_o |

## Verification
The assertions assume that `rd_data_i` follows `rd_addr_o` within the same cycle. They also assume that the host holds `cmd_data_i` steady while `cmd_valid_i` waits against a low `cmd_ready_o`. The bench models the external register file as an array indexed directly by `rd_addr_o`, updated only on `wr_en_o`. It holds one command byte while a response is left pending and drops the command before it releases that response. Every response is consumed before the next command is sent.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] OP_ADDR_LO  = 4'h0;
  localparam logic [NIB_W-1:0] OP_ADDR_HI  = 4'h1;
  localparam logic [NIB_W-1:0] OP_DATA_LO  = 4'h2;
  localparam logic [NIB_W-1:0] OP_DATA_WR  = 4'h3;
  localparam logic [NIB_W-1:0] OP_READ     = 4'h4;
  localparam logic [NIB_W-1:0] OP_READ_INC = 4'h5;
endpackage

// File: rtl/nib_cmd_parse.sv
module nib_cmd_parse
  import nib_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_data_i,
  input  logic              busy_i,
  output logic              cmd_ready_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  logic [NIB_W-1:0]  op, nib, lo_q;
  logic [BYTE_W-1:0] addr_q;
  logic              accept, legal;

  assign op          = cmd_data_i[BYTE_W-1:NIB_W];
  assign nib         = cmd_data_i[NIB_W-1:0];
  assign cmd_ready_o = ~busy_i;
  assign accept      = cmd_valid_i & ~busy_i;
  assign legal       = (op <= OP_READ_INC);

  always_comb begin
    wr_en_o   = accept && (op == OP_DATA_WR);
    wr_data_o = {nib, lo_q};
    rd_req_o  = accept && ((op == OP_READ) || (op == OP_READ_INC));
  end
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else if (accept) begin
      case (op)
        OP_ADDR_LO:  addr_q[NIB_W-1:0]      <= nib;
        OP_ADDR_HI:  addr_q[BYTE_W-1:NIB_W] <= nib;
        OP_DATA_LO:  lo_q                   <= nib;
        OP_READ_INC: addr_q                 <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  assert_inc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_READ_INC) |=> (addr_o == $past(addr_o) + 8'd1));

  assert_write_keeps_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> $stable(addr_o));

  assert_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !legal) |=> $stable(addr_o) && $stable(lo_q));

  assert_ignore_nowrite_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !legal) |-> !wr_en_o && !rd_req_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(addr_o) && $stable(lo_q));
endmodule

// File: rtl/nib_rsp_unit.sv
module nib_rsp_unit
  import nib_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_ADDR      = 8'h00,
  parameter logic [BYTE_W-1:0] ID_VALUE     = 8'hA6,
  parameter logic [BYTE_W-1:0] SCRATCH_ADDR = 8'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [BYTE_W-1:0] ext_rd_data_i,
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_data_o
);
  logic [BYTE_W-1:0] scratch_q, rd_mux;

  always_comb begin
    if (addr_i == ID_ADDR)           rd_mux = ID_VALUE;
    else if (addr_i == SCRATCH_ADDR) rd_mux = scratch_q;
    else                             rd_mux = ext_rd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scratch_q <= '0;
    else if (wr_en_i && addr_i == SCRATCH_ADDR) scratch_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else if (rd_req_i) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= rd_mux;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  assert_rsp_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rsp_valid_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_data_o));

  assert_no_read_when_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !rd_req_i);

  assert_id_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && addr_i == ID_ADDR) |=> rsp_data_o == ID_VALUE);
endmodule

// File: rtl/nib_reg_decoder.sv
module nib_reg_decoder
  import nib_pkg::*;
#(
  parameter logic [7:0] ID_ADDR      = 8'h00,
  parameter logic [7:0] ID_VALUE     = 8'hA6,
  parameter logic [7:0] SCRATCH_ADDR = 8'h0F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_data_i,
  output logic       cmd_ready_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  input  logic       rsp_ready_i,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  logic [BYTE_W-1:0] addr;
  logic              rd_req;

  nib_cmd_parse u_parse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_data_i  (cmd_data_i),
    .busy_i      (rsp_valid_o),
    .cmd_ready_o (cmd_ready_o),
    .addr_o      (addr),
    .wr_en_o     (wr_en_o),
    .wr_data_o   (wr_data_o),
    .rd_req_o    (rd_req)
  );

  nib_rsp_unit #(
    .ID_ADDR      (ID_ADDR),
    .ID_VALUE     (ID_VALUE),
    .SCRATCH_ADDR (SCRATCH_ADDR)
  ) u_rsp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (addr),
    .wr_en_i       (wr_en_o),
    .wr_data_i     (wr_data_o),
    .rd_req_i      (rd_req),
    .ext_rd_data_i (rd_data_i),
    .rsp_ready_i   (rsp_ready_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o)
  );

  assign wr_addr_o = addr;
  assign rd_addr_o = addr;

  assert_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);
endmodule

// File: tb/tb_nib_reg_decoder.sv
module tb_nib_reg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // {expects_response, command, expected byte}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h40, 8'hA6},  // R7 id
    {1'b0, 8'h0F, 8'h00},  // R2
    {1'b0, 8'h10, 8'h00},  // R2 -> 0x0F
    {1'b1, 8'h40, 8'h00},  // R1 scratch reset
    {1'b0, 8'h25, 8'h00},
    {1'b0, 8'h35, 8'h00},
    {1'b1, 8'h40, 8'h55},  // R8
    {1'b0, 8'h2A, 8'h00},
    {1'b0, 8'h3A, 8'h00},
    {1'b1, 8'h40, 8'hAA},  // R8
    {1'b0, 8'h00, 8'h00},
    {1'b0, 8'h12, 8'h00},  // addr 0x20
    {1'b1, 8'h50, 8'h11},  // R6 counters
    {1'b1, 8'h50, 8'h22},
    {1'b1, 8'h50, 8'h33},
    {1'b1, 8'h50, 8'h44},
    {1'b1, 8'h50, 8'h55},
    {1'b1, 8'h50, 8'h66},
    {1'b1, 8'h40, 8'h77},  // R9 at 0x26
    {1'b0, 8'h63, 8'h00},  // R11
    {1'b0, 8'hF1, 8'h00},  // R11
    {1'b1, 8'h40, 8'h77}   // R11 address kept
  };
  string vec_tag [NV] = '{"R7","R2","R2","R1","R8","R8","R8","R8","R8","R8",
                          "R2","R2","R6","R6","R6","R6","R6","R6","R9",
                          "R11","R11","R11"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       rsp_ready = 1'b0;
  logic       cmd_ready, rsp_valid, wr_en;
  logic [7:0] rsp_data, wr_addr, wr_data, rd_addr, rd_data;

  logic [7:0] ext_mem [256];
  int         wr_count = 0;
  logic [7:0] last_wr_addr = '0, last_wr_data = '0;
  int         n_tests = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_reg_decoder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_ready_i(rsp_ready),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign rd_data = ext_mem[rd_addr];

  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      ext_mem[wr_addr] <= wr_data;
      last_wr_addr     <= wr_addr;
      last_wr_data     <= wr_data;
      wr_count         <= wr_count + 1;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, accepted at the next rising edge
  task automatic do_cmd(logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get_rsp(string tag, logic [7:0] exp);
    check(tag, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    check(tag, "rsp_data", {24'd0, rsp_data}, {24'd0, exp});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(tag, "rsp_valid after take", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    for (int i = 0; i < 256; i++) ext_mem[i] = 8'h00;
    ext_mem[8'h20] = 8'h11; ext_mem[8'h21] = 8'h22; ext_mem[8'h22] = 8'h33;
    ext_mem[8'h23] = 8'h44; ext_mem[8'h24] = 8'h55; ext_mem[8'h25] = 8'h66;
    ext_mem[8'h26] = 8'h77; ext_mem[8'hFF] = 8'hEE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    check("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1", "address", {24'd0, rd_addr}, 32'd0);

    // R12 data-high with no data-low since reset
    c0 = wr_count;
    do_cmd(8'h37);
    check("R12", "write count", wr_count, c0 + 1);
    check("R12", "write addr", {24'd0, last_wr_addr}, 32'h00);
    check("R12", "write data", {24'd0, last_wr_data}, 32'h70);

    for (int v = 0; v < NV; v++) begin
      do_cmd(VEC[v][15:8]);
      if (VEC[v][16]) get_rsp(vec_tag[v], VEC[v][7:0]);
      else check(vec_tag[v], "no response", {31'd0, rsp_valid}, 32'd0);
    end

    // R2 nibble-wise address load, other half kept (address 0x26 here)
    do_cmd(8'h0C);
    check("R2", "low nibble", {24'd0, rd_addr}, 32'h2C);
    do_cmd(8'h19);
    check("R2", "high nibble", {24'd0, rd_addr}, 32'h9C);

    // R3 / R4 write pairs to one address
    c0 = wr_count;
    do_cmd(8'h21);
    check("R3", "data-low writes nothing", wr_count, c0);
    do_cmd(8'h3B);
    check("R3", "write count", wr_count, c0 + 1);
    check("R3", "write addr", {24'd0, last_wr_addr}, 32'h9C);
    check("R3", "write data", {24'd0, last_wr_data}, 32'hB1);
    do_cmd(8'h24);
    do_cmd(8'h3C);
    check("R4", "second write count", wr_count, c0 + 2);
    check("R4", "second write data", {24'd0, last_wr_data}, 32'hC4);
    check("R4", "address kept", {24'd0, rd_addr}, 32'h9C);
    do_cmd(8'h40);
    get_rsp("R9", 8'hC4);

    // R10 pending response blocks commands
    do_cmd(8'h40);
    cmd_valid = 1'b1;
    cmd_data  = 8'h0F;
    repeat (3) @(negedge clk);
    check("R10", "held valid", {31'd0, rsp_valid}, 32'd1);
    check("R10", "held data", {24'd0, rsp_data}, 32'hC4);
    check("R10", "cmd_ready low", {31'd0, cmd_ready}, 32'd0);
    check("R10", "command not consumed", {24'd0, rd_addr}, 32'h9C);
    cmd_valid = 1'b0;
    get_rsp("R10", 8'hC4);

    // R5 single byte per read
    check("R5", "one byte only", {31'd0, rsp_valid}, 32'd0);

    // R6 wrap from 0xFF
    do_cmd(8'h0F);
    do_cmd(8'h1F);
    do_cmd(8'h50);
    get_rsp("R6", 8'hEE);
    check("R6", "wrapped address", {24'd0, rd_addr}, 32'h00);
    do_cmd(8'h40);
    get_rsp("R7", 8'hA6);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule